// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is the configurable AND/OR core of a small programmable logic device. Ten dedicated input pins and eight feedback signals each feed a true line and a complement line, 36 lines in all. A product term ANDs every line that its connection mask selects. A fixed OR plane sums groups of product terms into eight outputs. Eleven more terms stand alone: eight per-output enables, a global preset, a global clear and a clock term.

Each of the 113 product terms has one 36-bit connection mask, kept in registers. They are loaded one term at a time through a word-addressed write port. A bulk-erase strobe opens every connection in one cycle. The array itself has no clock: the outputs follow the pins, the feedbacks and the masks currently stored.

Top module: `sop_array`

## Requirements
- R1: Signal s (pins 0..9 are signals 0..9, feedbacks 0..7 are signals 10..17) drives line 2s with its true value and line 2s+1 with its complement. Mask bit b set means line b is connected. A product term is the AND of its connected lines.
- R2: A product term with no connected line evaluates TRUE.
- R3: A product term connected to both lines of the same signal evaluates FALSE, so it does not contribute to its OR output.
- R4: Terms 0..101 are sum terms. Output k is the OR of a contiguous group of terms, with group sizes 8, 10, 12, 14, 16, 14, 12, 16 for k = 0..7. The groups start at terms 0, 8, 18, 30, 44, 60, 74 and 86.
- R5: Term 102+k is the enable of output k. Term 110 is the preset, term 111 is the clear and term 112 is the clock term.
- R6: When cfg_we is high at a rising clock edge, cfg_mask is stored for term cfg_idx. The new mask takes effect once that edge has passed.
- R7: When cfg_erase is high at a rising edge, every mask is cleared in that single cycle, and this takes priority over a write made in the same cycle.
- R8: A write with cfg_idx of 113 or above changes no mask.
- R9: A synchronous active-high reset clears every mask, so after reset every output, enable and special term reads 1.
- R10: The outputs respond to changes on the pins and feedbacks within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst | input | 1 | Synchronous active-high reset; clears all masks |
| cfg_we | input | 1 | Write strobe for one term's mask |
| cfg_erase | input | 1 | Bulk-erase strobe |
| cfg_idx | input | 7 | Product-term index for the write |
| cfg_mask | input | 36 | Connection mask to store |
| pin_i | input | 10 | Dedicated input pins |
| fb_i | input | 8 | Feedback signals |
| sum_o | output | 8 | OR-plane outputs |
| oe_o | output | 8 | Per-output enable terms |
| preset_o | output | 1 | Global preset term |
| clear_o | output | 1 | Global clear term |
| clk_term_o | output | 1 | Clock product term |

## Verification
The bench places one live term at each end of two OR groups, the last term of output 6 (index 85) and the last of output 7 (index 101). A design with a group off by one would then drive the wrong output or leave one dead. Every other sum term carries a true-and-complement pair: if that pair were not treated as FALSE, every output would stick at 1. Erase is issued in the same cycle as a write to check that the erase wins, and out-of-range indices are written to check that they do not alias onto a real term. Inputs are changed between clock edges to catch any array evaluation that has been registered by mistake.

// File: rtl/sop_pkg.sv
package sop_pkg;

    localparam int N_PIN   = 10;
    localparam int N_FB    = 8;
    localparam int N_SIG   = N_PIN + N_FB;
    localparam int N_LINE  = 2 * N_SIG;
    localparam int N_OUT   = 8;
    localparam int N_SUM   = 102;
    localparam int N_TERM  = N_SUM + N_OUT + 3;
    localparam int IDX_W   = $clog2(N_TERM);
    localparam int T_OE0   = N_SUM;
    localparam int T_PRE   = N_SUM + N_OUT;
    localparam int T_CLR   = T_PRE + 1;
    localparam int T_CLK   = T_PRE + 2;

    typedef logic [N_LINE-1:0] fuse_row_t;

    typedef struct packed {
        logic [N_OUT-1:0] oe;
        logic             preset;
        logic             clear;
        logic             clock;
    } ctrl_terms_t;

    function automatic int grp_size(input int k);
        case (k)
            0: return 8;
            1: return 10;
            2: return 12;
            3: return 14;
            4: return 16;
            5: return 14;
            6: return 12;
            default: return 16;
        endcase
    endfunction

    function automatic int grp_base(input int k);
        int acc;
        acc = 0;
        for (int j = 0; j < k; j++) acc += grp_size(j);
        return acc;
    endfunction

    // Even line = true value, odd line = complement.
    function automatic fuse_row_t build_lines(input logic [N_PIN-1:0] pins,
                                              input logic [N_FB-1:0]  fbs);
        logic [N_SIG-1:0] sig;
        fuse_row_t        ln;
        sig = {fbs, pins};
        for (int s = 0; s < N_SIG; s++) begin
            ln[2*s]   = sig[s];
            ln[2*s+1] = ~sig[s];
        end
        return ln;
    endfunction

    function automatic logic has_pair(input fuse_row_t row);
        logic hit;
        hit = 1'b0;
        for (int s = 0; s < N_SIG; s++) hit |= row[2*s] & row[2*s+1];
        return hit;
    endfunction

endpackage

// File: rtl/sop_fuse_store.sv
module sop_fuse_store
    import sop_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic                 cfg_erase,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  fuse_row_t            cfg_mask,
    output fuse_row_t            mask_o [N_TERM]
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_TERM - 1);

    fuse_row_t mask_q [N_TERM];
    fuse_row_t any_conn;

    always_ff @(posedge clk) begin
        if (rst || cfg_erase) begin
            for (int t = 0; t < N_TERM; t++) mask_q[t] <= '0;
        end else if (cfg_we && (cfg_idx <= LAST_IDX)) begin
            mask_q[cfg_idx] <= cfg_mask;
        end
    end

    always_comb begin
        any_conn = '0;
        for (int t = 0; t < N_TERM; t++) any_conn |= mask_q[t];
    end

    assign mask_o = mask_q;

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_erase && (cfg_idx <= LAST_IDX))
        |=> (mask_q[$past(cfg_idx)] == $past(cfg_mask)));  // R6

    AST_ERASE_ALL: assert property (@(posedge clk) disable iff (rst)
        cfg_erase |=> (any_conn == '0));  // R7

endmodule

// File: rtl/sop_term_eval.sv
module sop_term_eval
    import sop_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  fuse_row_t        lines,
    input  fuse_row_t        mask_i [N_TERM],
    output logic [N_TERM-1:0] term_o
);

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic pair_hit;
        logic empty;
        assign term_o[t] = &(lines | ~mask_i[t]);
        assign pair_hit  = has_pair(mask_i[t]);
        assign empty     = (mask_i[t] == '0);

        AST_EMPTY_TRUE: assert property (@(posedge clk) disable iff (rst)
            empty |-> term_o[t]);  // R2

        AST_PAIR_FALSE: assert property (@(posedge clk) disable iff (rst)
            pair_hit |-> !term_o[t]);  // R3
    end

endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane
    import sop_pkg::*;
(
    input  logic [N_TERM-1:0] term_i,
    output logic [N_OUT-1:0]  sum_o,
    output ctrl_terms_t       ctrl_o
);

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        localparam int BASE = grp_base(k);
        localparam int SIZE = grp_size(k);
        assign sum_o[k]     = |term_i[BASE +: SIZE];
        assign ctrl_o.oe[k] = term_i[T_OE0 + k];
    end

    assign ctrl_o.preset = term_i[T_PRE];
    assign ctrl_o.clear  = term_i[T_CLR];
    assign ctrl_o.clock  = term_i[T_CLK];

endmodule

// File: rtl/sop_array.sv
module sop_array
    import sop_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic                 cfg_erase,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [N_LINE-1:0]    cfg_mask,
    input  logic [N_PIN-1:0]     pin_i,
    input  logic [N_FB-1:0]      fb_i,
    output logic [N_OUT-1:0]     sum_o,
    output logic [N_OUT-1:0]     oe_o,
    output logic                 preset_o,
    output logic                 clear_o,
    output logic                 clk_term_o
);

    fuse_row_t         masks [N_TERM];
    fuse_row_t         lines;
    logic [N_TERM-1:0] terms;
    ctrl_terms_t       ctrl;

    assign lines = build_lines(pin_i, fb_i);

    sop_fuse_store u_store (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_erase (cfg_erase),
        .cfg_idx   (cfg_idx),
        .cfg_mask  (cfg_mask),
        .mask_o    (masks)
    );

    sop_term_eval u_eval (
        .clk    (clk),
        .rst    (rst),
        .lines  (lines),
        .mask_i (masks),
        .term_o (terms)
    );

    sop_or_plane u_or (
        .term_i (terms),
        .sum_o  (sum_o),
        .ctrl_o (ctrl)
    );

    assign oe_o       = ctrl.oe;
    assign preset_o   = ctrl.preset;
    assign clear_o    = ctrl.clear;
    assign clk_term_o = ctrl.clock;

    AST_ERASE_OUTS_HIGH: assert property (@(posedge clk) disable iff (rst)
        cfg_erase |=> (&sum_o && &oe_o && preset_o && clear_o && clk_term_o));  // R7

    AST_RESET_OUTS_HIGH: assert property (@(posedge clk)
        rst |=> (&sum_o && &oe_o && preset_o && clear_o && clk_term_o));  // R9

endmodule

// File: tb/sop_array_tb.sv
module sop_array_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_erase = 1'b0;
    logic [6:0]  cfg_idx = '0;
    logic [35:0] cfg_mask = '0;
    logic [9:0]  pin_i = '0;
    logic [7:0]  fb_i = '0;
    logic [7:0]  sum_o, oe_o;
    logic        preset_o, clear_o, clk_term_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    sop_array dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_erase(cfg_erase),
        .cfg_idx(cfg_idx), .cfg_mask(cfg_mask), .pin_i(pin_i), .fb_i(fb_i),
        .sum_o(sum_o), .oe_o(oe_o), .preset_o(preset_o), .clear_o(clear_o),
        .clk_term_o(clk_term_o)
    );

    localparam logic [35:0] PAIR = 36'h3;
    localparam logic [19:0] ALL_ONE = 20'hFFFFF;

    // {pins, fb, sum, oe0, preset, clear, clock}
    localparam logic [29:0] VEC [4] = '{
        {10'h000, 8'h00, 8'h94, 1'b0, 1'b0, 1'b0, 1'b0},
        {10'h3FF, 8'hFF, 8'h4B, 1'b1, 1'b1, 1'b0, 1'b1},
        {10'h206, 8'h01, 8'hBE, 1'b0, 1'b0, 1'b0, 1'b0},
        {10'h0D9, 8'h82, 8'h41, 1'b0, 1'b1, 1'b0, 1'b1}
    };

    function automatic logic [19:0] outs();
        return {sum_o, oe_o, preset_o, clear_o, clk_term_o, 1'b1};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [35:0] m);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 7'(idx); cfg_mask = m;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic erase();
        @(negedge clk);
        cfg_erase = 1'b1;
        @(negedge clk);
        cfg_erase = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        chk("R9 reset all high", 32'(outs()), 32'(ALL_ONE));

        // R7: erase wins over simultaneous write of a contradicting mask
        @(negedge clk);
        cfg_erase = 1'b1; cfg_we = 1'b1; cfg_idx = 7'd0; cfg_mask = PAIR;
        @(negedge clk);
        cfg_erase = 1'b0; cfg_we = 1'b0;
        #2;
        chk("R7 erase beats write", 32'(sum_o), 32'hFF);

        // R8: out-of-range indices touch nothing
        for (int i = 113; i < 128; i++) wr(i, PAIR);
        #2;
        chk("R8 out-of-range write ignored", 32'(outs()), 32'(ALL_ONE));

        // R6: a single write takes effect after its edge
        wr(111, PAIR);
        #2;
        chk("R6 write visible on clear", 32'(clear_o), 32'h0);
        chk("R3 pair term false", 32'(clear_o), 32'h0);

        // Program pattern (R4, R5)
        for (int t = 0; t < 102; t++) wr(t, PAIR);
        wr(0,   36'h1);
        wr(8,   36'h14);
        wr(18,  36'h80);
        wr(30,  36'h1 << 20);
        wr(44,  36'h1 << 35);
        wr(60,  (36'h1 << 18) | (36'h1 << 27));
        wr(85,  36'h1 << 8);
        wr(101, 36'h2);
        wr(102, 36'h1 << 10);
        wr(110, (36'h1 << 12) | (36'h1 << 14));
        wr(112, 36'h1 << 22);

        // Vector walk: inputs change between edges (R10)
        foreach (VEC[v]) begin
            @(negedge clk);
            pin_i = VEC[v][29:20];
            fb_i  = VEC[v][19:12];
            #2;
            chk("R1 R3 R4 sum outputs", 32'(sum_o), 32'(VEC[v][11:4]));
            chk("R5 enable term", 32'(oe_o), {24'h0, 7'h7F, VEC[v][3]});
            chk("R5 preset term", 32'(preset_o), 32'(VEC[v][2]));
            chk("R5 clear term", 32'(clear_o), 32'(VEC[v][1]));
            chk("R5 clock term", 32'(clk_term_o), 32'(VEC[v][0]));
        end

        // R10: mid-cycle change, no edge in between
        @(posedge clk);
        #3;
        pin_i = 10'h001; fb_i = 8'h00;
        #2;
        chk("R10 comb response a", 32'(sum_o), 32'h15);
        pin_i = 10'h000;
        #2;
        chk("R10 comb response b", 32'(sum_o), 32'h94);

        // R2: erased array gives all-ones regardless of inputs
        erase();
        pin_i = 10'h155; fb_i = 8'hA5;
        #2;
        chk("R2 empty terms true", 32'(outs()), 32'(ALL_ONE));

        // R9: reset after programming clears masks
        wr(111, PAIR);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #2;
        chk("R9 reset clears masks", 32'(outs()), 32'(ALL_ONE));

        finish_run();
    end

endmodule